// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Idle Queueing

This block serializes characters onto a single output line at one bit per baud tick. A one-entry holding buffer sits in front of a shift register, so software can write the next character while the current one is still on the line. Three kinds of frame go through the shifter: data characters, idle preambles (a whole frame at the resting level) and break characters (a whole frame at logic 0, optionally stretched).

Raising the enable input queues one idle preamble. A rising edge on the break request queues one break. If the request is still held when that break enters the shifter, another break is queued. When the enable drops, the block keeps the line until every frame already in the shifter or queued as idle or break has gone out. It then reports that it no longer owns the pin. Baud-rate generation happens outside the block. The caller supplies a single-cycle `baud_tick` strobe.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `tx_done` is 1 and `pin_owned` is 0.
- R2: When `line_invert` is 1, every level on `txd` is complemented: the idle level, break frames and data bits alike.
- R3: A rising edge of `tx_en` queues one idle preamble. It lasts 10 + `nine_bit` + `two_stop` bit times of the idle level.
- R4: A data frame is sent with bit 0 first. It is one start bit (0), then `wr_data` bit 0 through bit 7, then `wr_bit8` only when `nine_bit` is 1, then one stop bit (1), then a second stop bit (1) when `two_stop` is 1. The frame is 10, 11 or 12 bits long.
- R5: The buffered character moves into the shifter only on a `baud_tick` when the shifter is free and `tx_en` is 1. `buf_empty` rises on that same edge. A write (`wr_en`) makes `buf_empty` 0 on the next edge. A write in the same cycle as a load replaces the buffer, and the old character is the one sent.
- R6: `tx_done` goes to 1 when the last bit of a frame ends and nothing is loaded in its place. It goes to 0 on the edge at which any frame (data, idle or break) starts.
- R7: A break frame holds the line at 0 for 10 + `nine_bit` + `two_stop` bit times. It holds for 3 more bit times when `long_break` is 1.
- R8: A rising edge of `break_req` while `tx_en` is 1 queues one break. If `break_req` and `tx_en` are both still 1 when a break loads into the shifter, one more break is queued.
- R9: When several items wait for a free shifter, it loads a queued idle preamble first, then a queued break, then buffered data.
- R10: After `tx_en` goes to 0, `pin_owned` stays 1 until the frame in progress and all queued idle and break frames have finished. Buffered data that has not yet been loaded is not sent while `tx_en` is 0, and it stays in the buffer.
- R11: Each bit occupies exactly one baud-tick interval. `txd` changes only on an edge where `baud_tick` was 1, or when `line_invert` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle strobe that marks each bit boundary |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character low eight bits |
| wr_bit8 | input | 1 | Ninth data bit, used when `nine_bit` is 1 |
| tx_en | input | 1 | Transmitter enable; a rising edge queues an idle preamble |
| break_req | input | 1 | Break request; a rising edge queues a break, and holding it repeats breaks |
| long_break | input | 1 | Adds three bit times to each break |
| nine_bit | input | 1 | Selects nine data bits |
| two_stop | input | 1 | Selects two stop bits |
| line_invert | input | 1 | Complements the whole output stream |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer can accept a character |
| tx_done | output | 1 | Shifter idle with nothing loaded after the last frame |
| pin_owned | output | 1 | Transmitter still owns the line |

## Verification
The hardest case to reach from the ports is three items waiting at once for one shifter load: an idle preamble, a break and a data character. Normally each one would drain as soon as a tick arrives. The stimulus holds the baud tick off, raises enable and break request together, writes a character, and only then lets ticks resume, so the load order is forced into the open. A similar approach covers a held break request that spans a load, and a disable issued mid-frame with a break already queued and new data written. A behavioural queue-of-bits model predicts every output on every clock.

// File: rtl/uart_tx_brk.sv
module uart_tx_brk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_bit8,
  input  logic       tx_en,
  input  logic       break_req,
  input  logic       long_break,
  input  logic       nine_bit,
  input  logic       two_stop,
  input  logic       line_invert,
  output logic       txd,
  output logic       buf_empty,
  output logic       tx_done,
  output logic       pin_owned
);
  localparam int SW = 15;
  localparam int CW = 4;

  logic [SW-1:0] shreg, data_frame;
  logic [CW-1:0] bit_cnt, base_len;
  logic [8:0]    buf_q;
  logic buf_full, idle_q, brk_q, en_d, brk_d, done_q;
  logic busy, free, ld_idle, ld_brk, ld_data, load;

  assign busy     = bit_cnt != '0;
  assign free     = bit_cnt <= CW'(1);
  assign base_len = CW'(10) + CW'(nine_bit) + CW'(two_stop);

  assign ld_idle = baud_tick & free & idle_q;
  assign ld_brk  = baud_tick & free & ~idle_q & brk_q;
  assign ld_data = baud_tick & free & ~idle_q & ~brk_q & buf_full & tx_en;
  assign load    = ld_idle | ld_brk | ld_data;

  always_comb begin
    data_frame      = '1;
    data_frame[0]   = 1'b0;
    data_frame[8:1] = buf_q[7:0];
    if (nine_bit) data_frame[9] = buf_q[8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '1;
      bit_cnt  <= '0;
      buf_q    <= '0;
      buf_full <= 1'b0;
      idle_q   <= 1'b0;
      brk_q    <= 1'b0;
      en_d     <= 1'b0;
      brk_d    <= 1'b0;
      done_q   <= 1'b1;
    end else begin
      en_d  <= tx_en;
      brk_d <= break_req;

      idle_q <= (idle_q & ~ld_idle) | (tx_en & ~en_d);

      if (ld_brk) brk_q <= break_req & tx_en;
      else        brk_q <= brk_q | (break_req & ~brk_d & tx_en);

      if (wr_en) buf_q <= {wr_bit8, wr_data};
      buf_full <= (buf_full & ~ld_data) | wr_en;

      if (load) begin
        done_q <= 1'b0;
        if (ld_data)      shreg <= data_frame;
        else if (ld_idle) shreg <= '1;
        else              shreg <= '0;
        bit_cnt <= ld_brk ? base_len + (long_break ? CW'(3) : CW'(0)) : base_len;
      end else if (baud_tick && busy) begin
        shreg   <= {1'b1, shreg[SW-1:1]};
        bit_cnt <= bit_cnt - CW'(1);
        if (bit_cnt == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign txd       = (busy ? shreg[0] : 1'b1) ^ line_invert;
  assign buf_empty = ~buf_full;
  assign tx_done   = done_q;
  assign pin_owned = tx_en | busy | idle_q | brk_q;
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic wr_en,
  input logic tx_en,
  input logic line_invert,
  input logic txd,
  input logic buf_empty,
  input logic tx_done,
  input logic pin_owned
);
  a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty);

  a_r5_empty_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(baud_tick));

  a_r6_done_rests_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (txd == line_invert ^ 1'b1));

  a_r6_done_clears_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_done) |-> $past(baud_tick));

  a_r10_release_drained: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_owned) |-> (tx_done && !tx_en));

  a_r11_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> ($past(baud_tick) || !$stable(line_invert)));
endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
  .tx_en(tx_en), .line_invert(line_invert), .txd(txd),
  .buf_empty(buf_empty), .tx_done(tx_done), .pin_owned(pin_owned)
);

// File: tb/uart_tx_brk_bench.sv
`timescale 1ns/1ps
module uart_tx_brk_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_bit8 = 1'b0;
  logic tx_en = 1'b0, break_req = 1'b0, long_break = 1'b0;
  logic nine_bit = 1'b0, two_stop = 1'b0, line_invert = 1'b0;
  logic txd, buf_empty, tx_done, pin_owned;

  always #5 clk = ~clk;

  uart_tx_brk u_uart_tx_brk (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .wr_bit8(wr_bit8), .tx_en(tx_en), .break_req(break_req),
    .long_break(long_break), .nine_bit(nine_bit), .two_stop(two_stop),
    .line_invert(line_invert), .txd(txd), .buf_empty(buf_empty),
    .tx_done(tx_done), .pin_owned(pin_owned)
  );

  int compared = 0, mismatched = 0;
  string phase = "R1";
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  // baud strobe: one pulse every tick_div clocks while enabled
  bit tick_on = 1'b0;
  int tick_div = 4;
  int tick_cnt = 0;
  always @(posedge clk) begin
    #1;
    if (tick_on) begin
      tick_cnt++;
      baud_tick = (tick_cnt % tick_div) == 0;
    end else baud_tick = 1'b0;
  end

  // behavioural reference: a queue of pending line levels
  bit line_q[$];
  bit m_idle, m_brk, m_full, m_done, m_en_d, m_brk_d;
  logic [8:0] m_buf;
  int kind, nbits;
  always @(posedge clk) begin
    if (!rst_n) begin
      line_q.delete();
      m_idle = 0; m_brk = 0; m_full = 0; m_done = 1; m_en_d = 0; m_brk_d = 0;
      m_buf = '0;
    end else begin
      kind = 0;
      if (baud_tick && line_q.size() <= 1) begin
        if (m_idle) kind = 1;
        else if (m_brk) kind = 2;
        else if (m_full && tx_en) kind = 3;
      end
      if (baud_tick) begin
        if (kind != 0) begin
          line_q.delete();
          nbits = 10 + int'(nine_bit) + int'(two_stop);
          if (kind == 1) repeat (nbits) line_q.push_back(1'b1);
          else if (kind == 2) repeat (nbits + (long_break ? 3 : 0)) line_q.push_back(1'b0);
          else begin
            line_q.push_back(1'b0);
            for (int i = 0; i < 8; i++) line_q.push_back(m_buf[i]);
            if (nine_bit) line_q.push_back(m_buf[8]);
            line_q.push_back(1'b1);
            if (two_stop) line_q.push_back(1'b1);
          end
          m_done = 0;
        end else if (line_q.size() > 0) begin
          void'(line_q.pop_front());
          if (line_q.size() == 0) m_done = 1;
        end
      end
      if (kind == 1) m_idle = 0;
      if (tx_en && !m_en_d) m_idle = 1;
      if (kind == 2) m_brk = break_req && tx_en;
      else if (break_req && !m_brk_d && tx_en) m_brk = 1;
      if (kind == 3) m_full = 0;
      if (wr_en) begin m_full = 1; m_buf = {wr_bit8, wr_data}; end
      m_en_d = tx_en;
      m_brk_d = break_req;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(phase, "txd", txd, (line_q.size() > 0 ? line_q[0] : 1'b1) ^ line_invert);
      chk(phase, "buf_empty", buf_empty, !m_full);
      chk(phase, "tx_done", tx_done, m_done);
      chk(phase, "pin_owned", pin_owned, tx_en | (line_q.size() > 0) | m_idle | m_brk);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic write_char(input logic b8, input logic [7:0] d);
    wr_en = 1'b1; wr_bit8 = b8; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_break();
    break_req = 1'b1;
    step(1);
    break_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    step(3);
    cmp_on = 1'b1;
    step(1);
    rst_n = 1'b1;
    step(1);
    // R1 explicit reset-state checks
    chk("R1", "txd", txd, 1'b1);
    chk("R1", "buf_empty", buf_empty, 1'b1);
    chk("R1", "tx_done", tx_done, 1'b1);
    chk("R1", "pin_owned", pin_owned, 1'b0);

    phase = "R3";
    tick_on = 1'b1;
    tx_en = 1'b1;
    write_char(1'b0, 8'hA5);
    step(120);

    phase = "R5";
    write_char(1'b0, 8'h3C);
    step(8);
    write_char(1'b0, 8'h5A);
    step(100);

    phase = "R4";
    nine_bit = 1'b1; two_stop = 1'b1;
    write_char(1'b1, 8'h81);
    step(70);
    nine_bit = 1'b0;
    write_char(1'b0, 8'hC3);
    step(60);
    two_stop = 1'b0;

    phase = "R7";
    pulse_break();
    step(60);
    long_break = 1'b1;
    pulse_break();
    step(80);
    long_break = 1'b0;

    phase = "R8";
    break_req = 1'b1;
    step(50);
    break_req = 1'b0;
    step(150);

    phase = "R2";
    line_invert = 1'b1;
    write_char(1'b0, 8'h0F);
    pulse_break();
    step(150);
    line_invert = 1'b0;
    step(4);

    phase = "R9";
    tx_en = 1'b0;
    step(6);
    tick_on = 1'b0;
    tx_en = 1'b1; break_req = 1'b1;
    write_char(1'b0, 8'h55);
    break_req = 1'b0;
    step(2);
    tick_on = 1'b1;
    step(200);

    phase = "R10";
    write_char(1'b0, 8'h99);
    step(12);
    pulse_break();
    step(3);
    tx_en = 1'b0;
    write_char(1'b0, 8'h77);
    step(200);
    chk("R10", "pin_owned", pin_owned, 1'b0);
    chk("R10", "buf_empty", buf_empty, 1'b0);
    chk("R6", "tx_done", tx_done, 1'b1);
    chk("R10", "txd", txd, 1'b1);

    phase = "R11";
    tick_div = 7;
    tx_en = 1'b1;
    step(200);
    write_char(1'b0, 8'hE1);
    step(120);
    chk("R6", "tx_done", tx_done, 1'b1);
    chk("R5", "buf_empty", buf_empty, 1'b1);

    phase = "R6";
    step(10);
    finish_run();
  end
endmodule